// File: doc/BRIEF.md
# Instruction-Boundary Event Arbiter

This block is consulted once at every instruction boundary of a processor core. It chooses which pending asynchronous condition to serve before the next instruction starts. The candidates are a debug trap, a maskable external interrupt and a DMA bus-hold request. If none of them applies, the core proceeds. The block keeps the pending-trap vector, a two-bit one-boundary inhibit shadow, a sticky debug-status register, the halt state and an async-pending summary flag.

The core raises `bnd_valid` for one cycle when a boundary is reached. At the following clock edge the block registers exactly one one-hot action. It holds that action until the core pulses `svc_done`. When an interrupt is chosen, the acknowledge vector presented on `ack_vec` is captured in the same edge, and the event is marked as external.

Other logic can post trap bits, inhibit shadows and a halt request in any cycle. Posts that arrive in the same cycle as a boundary evaluation apply to the next boundary. A halted core ignores boundaries until an interrupt request arrives while the interrupt-enable flag is set.

Top module: `boundary_event_arbiter`

## Requirements
- R1: After a synchronous active-low reset, `act_valid`, `act_oh`, `pend_traps`, `dbg_status`, `halted`, `async_pend`, `irq_ext` and `irq_vec` are all zero, and the inhibit shadows are clear.
- R2: A boundary is accepted only when no action is outstanding (`act_valid`=0). One clock after acceptance, `act_valid`=1 and `act_oh` holds exactly one bit: bit 3 debug exception, bit 2 interrupt acknowledge, bit 1 hold acknowledge, bit 0 proceed. The action stays unchanged until `svc_done`, after which `act_valid` drops at the next edge. A boundary request made while an action is outstanding is ignored.
- R3: `halt_req` sets `halted`. While halted, boundaries are ignored unless `intr` and `ie` are both high. Such a wake-up boundary clears `halted`, the pending traps and the inhibit shadows, and is then evaluated normally, so it yields an interrupt acknowledge.
- R4: If pending-trap bit 15 (task-switch trap) is set, the action is debug, even when the debug shadow is active.
- R5: Any other nonzero pending trap gives a debug action unless the debug shadow (`inh_set` bit 0) is active for this boundary. An inhibited trap stays pending.
- R6: When no debug action is taken, an interrupt is taken if the interrupt shadow (`inh_set` bit 1) is inactive and `intr` and `ie` are both high. `irq_vec` captures `ack_vec` and `irq_ext` is set. `irq_ext` is cleared by any other accepted action.
- R7: When neither a debug action nor an interrupt is taken and `hold_req` is high, the action is hold acknowledge.
- R8: When no other action applies, the action is proceed.
- R9: On any accepted boundary with a non-debug action, a high `tf` sets pending bit 14 (single step), so the next boundary raises a debug action.
- R10: Both inhibit shadows are cleared by every accepted boundary. An event they blocked is served at the next boundary.
- R11: Each accepted boundary sets `async_pend` to (`intr` or `hold_req` or `tf` or any pending trap after evaluation). A trap post or halt request sets `async_pend`.
- R12: A debug action ORs the pending traps into `dbg_status` and clears the pending vector. `dbg_status` never loses a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bnd_valid | input | 1 | Instruction boundary reached, evaluate now |
| svc_done | input | 1 | Outstanding action has been serviced |
| trap_post | input | 16 | Trap bits ORed into the pending vector |
| inh_set | input | 2 | Shadow set: bit 0 debug, bit 1 interrupt |
| halt_req | input | 1 | Enter halt state |
| tf | input | 1 | Trap (single-step) flag |
| ie | input | 1 | Interrupt-enable flag |
| intr | input | 1 | External interrupt request |
| hold_req | input | 1 | DMA bus-hold request |
| ack_vec | input | 8 | Vector returned by the interrupt acknowledge |
| act_valid | output | 1 | An action is outstanding |
| act_oh | output | 4 | One-hot action (3 debug, 2 irq, 1 hold, 0 proceed) |
| irq_vec | output | 8 | Last captured interrupt vector |
| irq_ext | output | 1 | Current event is an external interrupt |
| pend_traps | output | 16 | Pending-trap vector |
| dbg_status | output | 16 | Sticky debug status |
| halted | output | 1 | Halt state |
| async_pend | output | 1 | Some asynchronous condition may be pending |

## Verification
On every cycle, the checker enforces the following:
- the action is one-hot and stays stable until it is serviced;
- a halted core without an enabled request accepts nothing;
- an interrupt action is preceded by an enabled request and is flagged external;
- a task-switch trap always wins;
- no debug-status bit is ever lost.

The relative order of debug, interrupt, hold and proceed under combined inputs, the one-boundary life of the shadows, single-step scheduling and the async-flag rule all depend on the history of posts. Only the bench's scenarios show those, by comparing every output against a reference model.

// File: rtl/bea_pkg.sv
// Shared definitions for the boundary event arbiter.
// Assumes a four-way one-hot action; index order is the service priority.
package bea_pkg;
    localparam int ACT_N  = 4;
    localparam int A_GO   = 0;
    localparam int A_HOLD = 1;
    localparam int A_IRQ  = 2;
    localparam int A_DBG  = 3;
    localparam int INH_W  = 2;
    localparam int INH_DBG = 0;
    localparam int INH_IRQ = 1;
    typedef logic [ACT_N-1:0] act_t;
endpackage

// File: rtl/bea_arbiter.sv
// Combinational priority evaluation for one boundary.
// Applies the halt wake-up clearing first, then picks the highest-priority
// request: debug, interrupt, hold, proceed. Also derives the next pending
// vector, the status contribution and the next async summary.
module bea_arbiter
    import bea_pkg::*;
#(
    parameter int TRAP_W = 16,
    parameter int TS_BIT = 15,
    parameter int SS_BIT = 14
) (
    input  logic [TRAP_W-1:0] pend,
    input  logic [INH_W-1:0]  inh,
    input  logic              halted,
    input  logic              intr,
    input  logic              ie,
    input  logic              tf,
    input  logic              hold_req,
    output logic              wake,
    output act_t              act,
    output logic [TRAP_W-1:0] pend_next,
    output logic [TRAP_W-1:0] status_or,
    output logic              async_next
);
    localparam logic [TRAP_W-1:0] SS_MASK = TRAP_W'(1) << SS_BIT;

    logic [TRAP_W-1:0] p_eff;
    logic [INH_W-1:0]  i_eff;
    act_t              req;
    logic              found;

    // Effective state after a possible wake-up, and raw request vector.
    always_comb begin
        wake       = halted & intr & ie;
        p_eff      = wake ? '0 : pend;
        i_eff      = wake ? '0 : inh;
        req        = '0;
        req[A_DBG] = p_eff[TS_BIT] | ((|p_eff) & ~i_eff[INH_DBG]);
        req[A_IRQ] = ~i_eff[INH_IRQ] & intr & ie;
        req[A_HOLD]= hold_req;
        req[A_GO]  = 1'b1;
    end

    // Fixed priority pick, highest index first.
    always_comb begin
        act   = '0;
        found = 1'b0;
        for (int k = ACT_N - 1; k >= 0; k--) begin
            if (req[k] && !found) begin
                act[k] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    // Post-evaluation trap vector, status merge and async summary.
    always_comb begin
        status_or  = act[A_DBG] ? p_eff : '0;
        pend_next  = act[A_DBG] ? '0 : (p_eff | (tf ? SS_MASK : '0));
        async_next = intr | hold_req | tf | (|pend_next);
    end
endmodule

// File: rtl/bea_state.sv
// Architectural state of the arbiter: pending traps, inhibit shadows,
// halt bit, sticky debug status and async summary.
// Posts arriving in an evaluation cycle apply after that evaluation.
module bea_state
    import bea_pkg::*;
#(
    parameter int TRAP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              wake,
    input  logic [TRAP_W-1:0] pend_next,
    input  logic [TRAP_W-1:0] status_or,
    input  logic              async_next,
    input  logic [TRAP_W-1:0] trap_post,
    input  logic [INH_W-1:0]  inh_set,
    input  logic              halt_req,
    output logic [TRAP_W-1:0] pend,
    output logic [INH_W-1:0]  inh,
    output logic              halted,
    output logic [TRAP_W-1:0] dstat,
    output logic              async_pend
);
    logic post_any;

    // Any external post that flags pending asynchronous work.
    always_comb post_any = (|trap_post) | halt_req;

    // Update pending vector and inhibit shadows at boundaries and on posts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            inh  <= '0;
        end else begin
            pend <= (fire ? pend_next : pend) | trap_post;
            inh  <= (fire ? '0 : inh) | inh_set;
        end
    end

    // Halt bit: cleared by a wake-up evaluation, set by a request.
    always_ff @(posedge clk) begin
        if (!rst_n) halted <= 1'b0;
        else        halted <= ((fire && wake) ? 1'b0 : halted) | halt_req;
    end

    // Sticky debug status and async summary flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dstat      <= '0;
            async_pend <= 1'b0;
        end else begin
            dstat      <= dstat | (fire ? status_or : '0);
            async_pend <= (fire ? async_next : async_pend) | post_any;
        end
    end
endmodule

// File: rtl/bea_handshake.sv
// Boundary acceptance and action hand-off.
// Accepts a boundary when idle and not blocked by halt, registers the
// chosen action and the acknowledge vector, and holds them until serviced.
module bea_handshake
    import bea_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bnd_valid,
    input  logic             svc_done,
    input  logic             halted,
    input  logic             wake,
    input  act_t             act_in,
    input  logic [VEC_W-1:0] ack_vec,
    output logic             fire,
    output logic             act_valid,
    output act_t             act,
    output logic [VEC_W-1:0] irq_vec,
    output logic             irq_ext
);
    // Acceptance condition for this cycle.
    always_comb fire = bnd_valid & ~act_valid & (~halted | wake);

    // Action register with done handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_valid <= 1'b0;
            act       <= '0;
            irq_ext   <= 1'b0;
        end else if (fire) begin
            act_valid <= 1'b1;
            act       <= act_in;
            irq_ext   <= act_in[A_IRQ];
        end else if (act_valid && svc_done) begin
            act_valid <= 1'b0;
            act       <= '0;
        end
    end

    // Acknowledge vector capture on interrupt acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)                    irq_vec <= '0;
        else if (fire && act_in[A_IRQ]) irq_vec <= ack_vec;
    end
endmodule

// File: rtl/boundary_event_arbiter.sv
// Top level of the instruction-boundary event arbiter.
// Assumes the core presents one boundary at a time and waits for the
// registered action before the next; ack_vec is valid with bnd_valid.
module boundary_event_arbiter
    import bea_pkg::*;
#(
    parameter int TRAP_W = 16,
    parameter int VEC_W  = 8,
    parameter int TS_BIT = 15,
    parameter int SS_BIT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bnd_valid,
    input  logic              svc_done,
    input  logic [TRAP_W-1:0] trap_post,
    input  logic [INH_W-1:0]  inh_set,
    input  logic              halt_req,
    input  logic              tf,
    input  logic              ie,
    input  logic              intr,
    input  logic              hold_req,
    input  logic [VEC_W-1:0]  ack_vec,
    output logic              act_valid,
    output logic [ACT_N-1:0]  act_oh,
    output logic [VEC_W-1:0]  irq_vec,
    output logic              irq_ext,
    output logic [TRAP_W-1:0] pend_traps,
    output logic [TRAP_W-1:0] dbg_status,
    output logic              halted,
    output logic              async_pend
);
    logic              fire, wake, async_next;
    act_t              act_sel;
    logic [TRAP_W-1:0] pend_next, status_or;
    logic [INH_W-1:0]  inh;

    bea_arbiter #(.TRAP_W(TRAP_W), .TS_BIT(TS_BIT), .SS_BIT(SS_BIT)) u_arb (
        .pend(pend_traps), .inh(inh), .halted(halted), .intr(intr), .ie(ie),
        .tf(tf), .hold_req(hold_req), .wake(wake), .act(act_sel),
        .pend_next(pend_next), .status_or(status_or), .async_next(async_next)
    );

    bea_state #(.TRAP_W(TRAP_W)) u_state (
        .clk(clk), .rst_n(rst_n), .fire(fire), .wake(wake),
        .pend_next(pend_next), .status_or(status_or), .async_next(async_next),
        .trap_post(trap_post), .inh_set(inh_set), .halt_req(halt_req),
        .pend(pend_traps), .inh(inh), .halted(halted), .dstat(dbg_status),
        .async_pend(async_pend)
    );

    bea_handshake #(.VEC_W(VEC_W)) u_hs (
        .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid), .svc_done(svc_done),
        .halted(halted), .wake(wake), .act_in(act_sel), .ack_vec(ack_vec),
        .fire(fire), .act_valid(act_valid), .act(act_oh), .irq_vec(irq_vec),
        .irq_ext(irq_ext)
    );
endmodule

// File: rtl/bea_checker.sv
// Port-level properties of the boundary event arbiter, bound to the top.
module bea_checker #(
    parameter int TRAP_W = 16,
    parameter int TS_BIT = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              svc_done,
    input logic              intr,
    input logic              ie,
    input logic              act_valid,
    input logic [3:0]        act_oh,
    input logic              irq_ext,
    input logic [TRAP_W-1:0] pend_traps,
    input logic [TRAP_W-1:0] dbg_status,
    input logic              halted
);
    p_onehot_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> ($countones(act_oh) == 1));

    p_hold_until_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && !svc_done) |=> (act_valid && $stable(act_oh)));

    p_halt_ignores_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !act_valid && !(intr && ie)) |=> !act_valid);

    p_irq_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(act_valid) && act_oh[2]) |-> $past(intr && ie));

    p_irq_external_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && act_oh[2]) |-> irq_ext);

    p_task_switch_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(act_valid) && $past(pend_traps[TS_BIT]) && !$past(halted))
        |-> act_oh[3]);

    p_status_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((dbg_status & $past(dbg_status)) == $past(dbg_status)));
endmodule

bind boundary_event_arbiter bea_checker #(.TRAP_W(TRAP_W), .TS_BIT(TS_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .svc_done(svc_done), .intr(intr), .ie(ie),
    .act_valid(act_valid), .act_oh(act_oh), .irq_ext(irq_ext),
    .pend_traps(pend_traps), .dbg_status(dbg_status), .halted(halted)
);

// File: tb/tb_boundary_event_arbiter.sv
module tb_boundary_event_arbiter;
    logic        clk = 0, rst_n = 0;
    logic        bnd_valid = 0, svc_done = 0, halt_req = 0;
    logic [15:0] trap_post = 0;
    logic [1:0]  inh_set = 0;
    logic        tf = 0, ie = 0, intr = 0, hold_req = 0;
    logic [7:0]  ack_vec = 0;
    logic        act_valid, irq_ext, halted, async_pend;
    logic [3:0]  act_oh;
    logic [7:0]  irq_vec;
    logic [15:0] pend_traps, dbg_status;

    int checks = 0, failures = 0;

    // reference model state
    logic [15:0] m_pend = 0, m_dstat = 0;
    logic [1:0]  m_inh = 0;
    logic        m_halt = 0, m_async = 0, m_ext = 0;
    logic [7:0]  m_vec = 0;

    always #5 clk = ~clk;

    boundary_event_arbiter dut (
        .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid), .svc_done(svc_done),
        .trap_post(trap_post), .inh_set(inh_set), .halt_req(halt_req),
        .tf(tf), .ie(ie), .intr(intr), .hold_req(hold_req), .ack_vec(ack_vec),
        .act_valid(act_valid), .act_oh(act_oh), .irq_vec(irq_vec),
        .irq_ext(irq_ext), .pend_traps(pend_traps), .dbg_status(dbg_status),
        .halted(halted), .async_pend(async_pend)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare all state outputs against the model.
    task automatic chk_state(input string tag);
        chk({tag, " pend"},  pend_traps, m_pend);
        chk({tag, " dstat"}, dbg_status, m_dstat);
        chk({tag, " halted"}, halted, m_halt);
        chk({tag, " async R11"}, async_pend, m_async);
    endtask

    task automatic post(input logic [15:0] t, input logic [1:0] s, input logic h);
        @(negedge clk);
        trap_post = t; inh_set = s; halt_req = h;
        @(negedge clk);
        trap_post = 0; inh_set = 0; halt_req = 0;
        m_pend |= t; m_inh |= s; m_halt |= h;
        if (t != 0 || h) m_async = 1;
        chk_state("R5 post");
    endtask

    // Expected action from the requirements: R3..R12.
    task automatic bnd(input string tag, input logic i_intr, i_ie, i_tf, i_hold,
                       input logic [7:0] v);
        logic acc, wk; logic [3:0] ea; logic [15:0] pe; logic id, ii;
        @(negedge clk);
        intr = i_intr; ie = i_ie; tf = i_tf; hold_req = i_hold; ack_vec = v;
        bnd_valid = 1;
        wk  = m_halt & i_intr & i_ie;
        acc = !m_halt || wk;
        ea  = 0;
        if (acc) begin
            pe = wk ? 16'h0 : m_pend;
            id = m_inh[0] & !wk;
            ii = m_inh[1] & !wk;
            if (pe[15] || (pe != 0 && !id))      ea = 4'b1000;
            else if (!ii && i_intr && i_ie)      ea = 4'b0100;
            else if (i_hold)                     ea = 4'b0010;
            else                                 ea = 4'b0001;
            if (ea[3]) begin m_dstat |= pe; m_pend = 0; end
            else m_pend = pe | (i_tf ? 16'h4000 : 16'h0);
            m_inh = 0;
            if (wk) m_halt = 0;
            if (ea[2]) m_vec = v;
            m_ext = ea[2];
            m_async = i_intr | i_hold | i_tf | (m_pend != 0);
        end
        @(negedge clk);
        bnd_valid = 0;
        if (acc) begin
            chk({tag, " valid R2"}, act_valid, 1);
            chk({tag, " act"}, act_oh, ea);
            chk({tag, " vec R6"}, irq_vec, m_vec);
            chk({tag, " ext R6"}, irq_ext, m_ext);
            chk_state(tag);
            svc_done = 1;
            @(negedge clk);
            svc_done = 0;
            chk({tag, " done R2"}, act_valid, 0);
        end else begin
            chk({tag, " ignored R3"}, act_valid, 0);
            chk_state({tag, " R3"});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", act_valid, 0);
        chk("R1 act", act_oh, 0);
        chk("R1 vec", irq_vec, 0);
        chk("R1 ext", irq_ext, 0);
        chk_state("R1");

        bnd("R8 quiet", 0, 0, 0, 0, 8'h00);
        bnd("R9 step arm", 0, 0, 1, 0, 8'h00);
        bnd("R9 step fire", 0, 0, 0, 0, 8'h00);
        post(16'h0008, 2'b01, 0);
        bnd("R5 inhibited trap", 1, 1, 0, 0, 8'h3c);
        bnd("R10 trap next", 0, 0, 0, 0, 8'h00);
        post(16'h8000, 2'b01, 0);
        bnd("R4 task switch", 1, 1, 0, 1, 8'h11);
        post(16'h0000, 2'b10, 0);
        bnd("R6 shadow hold", 1, 1, 0, 1, 8'h22);
        bnd("R10 irq next", 1, 1, 0, 1, 8'hc7);
        bnd("R7 hold", 1, 0, 0, 1, 8'h00);
        post(16'h0004, 2'b11, 1);
        bnd("R3 halted", 1, 0, 0, 0, 8'h00);
        bnd("R3 halted", 0, 1, 0, 1, 8'h00);
        bnd("R3 wake", 1, 1, 0, 0, 8'h5a);

        // R2: a second boundary while an action is outstanding is ignored.
        @(negedge clk);
        hold_req = 1; intr = 0; tf = 0; bnd_valid = 1;
        @(negedge clk);
        bnd_valid = 0;
        chk("R2 first", act_oh, 4'b0010);
        hold_req = 0; intr = 1; ie = 1; ack_vec = 8'hee; bnd_valid = 1;
        @(negedge clk);
        bnd_valid = 0;
        chk("R2 held", act_oh, 4'b0010);
        chk("R2 vec kept", irq_vec, m_vec);
        svc_done = 1;
        @(negedge clk);
        svc_done = 0; intr = 0;
        chk("R2 released", act_valid, 0);
        m_ext = 0; m_async = 1;
        chk("R6 ext cleared", irq_ext, 0);

        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(3, 0) == 0) begin
                logic [15:0] t;
                t = 16'h0;
                if ($urandom_range(1, 0) == 1) t[$urandom_range(15, 0)] = 1'b1;
                post(t, 2'($urandom_range(3, 0)), ($urandom_range(15, 0) == 0));
            end
            bnd("RND R4-prio", 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
                ($urandom_range(5, 0) == 0), 1'($urandom_range(1, 0)),
                8'($urandom_range(255, 0)));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule